// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs the bus cycles of a 16-bit local bus on which one set of lines carries first the address and then the data. A requester presents a 20-bit address, a direction, a byte-or-word size and a flag saying whether the transfer comes from the processor core or from a DMA engine. The sequencer accepts the request and walks through the T-states T1, T2, T3, zero or more TW wait states, and T4. While it does so it drives the address-latch strobe, the active-low read and write strobes, the byte-high-enable line and the status code on the upper address lines.

The shared lines carry address bits 15..0 in T1 and data afterwards. On a read they are released so that the addressed device can drive data, which is captured at the end of the last T3/TW. A slow device holds `rdy` low to stretch the cycle. An external master can take the bus with `hold_req`. The sequencer grants it only between cycles and then releases every bus line it can float. The pads are modelled as separate output, output-enable and input signals, so the block sits beside the chip's own pad ring.

Top module: `mux_bus_seq`

## Requirements
- R1: While `rst_n` is low, `ad_oe` and `ctl_oe` are 0, `ale` is 0 and `hold_ack` is 0.
- R2: An accepted request (`req_accept` high in IDLE or T4) is followed by exactly one T1 cycle. In that cycle `ale` is 1, `ad_oe` is 1, `ad_out` equals address bits 15..0 and `ahi_out` equals address bits 19..16. `ale` is 0 in every other cycle.
- R3: In T2, T3, TW and T4, `ahi_out` bit 3 is 1 for a DMA-originated cycle and 0 for a core-originated one, and bits 2..0 are 0.
- R4: In T1 the pair {`bhe_n`, `ad_out[0]`} is 00 for a word, 01 for a byte on the upper lane (odd address) and 10 for a byte on the lower lane (even address). The value 11 never appears.
- R5: `bhe_n` keeps its T1 value through T2, T3, TW and T4.
- R6: On a write, `wr_n` is 0 exactly in T2, T3 and TW. From T2 through T4, `ad_oe` is 1 and `ad_out` carries the write data.
- R7: On a read, `rd_n` is 0 exactly in T2, T3 and TW and `ad_oe` is 0 from T2 through T4. `ad_in` is captured at the edge that ends the final T3/TW. `rdata_valid` is 1 during T4, and `rdata` holds the captured value until the next capture.
- R8: `rdy` is sampled at the end of T3 and of each TW. When it is low another TW follows. When it is high T4 follows, so a cycle lasts 4 plus the number of low samples.
- R9: `hold_req` is honoured only in IDLE or T4. A hold raised during a cycle lets that cycle run to T4, and `hold_ack` rises in the next cycle. While `hold_ack` is 1, `ctl_oe` and `ad_oe` are 0 and no request is accepted.
- R10: A word request with address bit 0 set is rejected. `req_err` pulses, `req_accept` stays 0 and no T1 follows.
- R11: With no request pending after T4, the sequencer returns to IDLE (`ale` 0). A request that is valid in T4 is accepted there, and T1 follows T4 directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_addr | input | 20 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_dma | input | 1 | 1 = DMA-originated, 0 = core-originated |
| req_wdata | input | 16 | Write data |
| req_accept | output | 1 | Request taken this cycle |
| req_err | output | 1 | Misaligned word request rejected this cycle |
| rdy | input | 1 | Device ready; low inserts wait states |
| hold_req | input | 1 | External bus hold request |
| hold_ack | output | 1 | Bus released to the holding master |
| ale | output | 1 | Address-latch strobe, active high, never floated |
| ad_out | output | 16 | Shared address/data lines, output value |
| ad_oe | output | 1 | Output enable of the shared lines |
| ad_in | input | 16 | Shared lines, input value |
| ahi_out | output | 4 | Upper address bits in T1, status afterwards |
| bhe_n | output | 1 | Byte-high-enable, active low, held as status after T1 |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| ctl_oe | output | 1 | Output enable for `ahi_out`, `bhe_n`, `wr_n`, `rd_n` |
| rdata | output | 16 | Captured read data |
| rdata_valid | output | 1 | High in the T4 that follows a read capture |

## Verification
The bench goes through every combination of direction, size, origin and address parity, with zero to two wait states. It checks each T-state's pin values against figures it computes from the request. Several faults show up here as a specific wrong pin value:
- a design that drives the origin status into the wrong bit, or drives it during T1, corrupts `ahi_out`;
- a design that encodes the lanes wrongly produces the wrong {`bhe_n`, A0} pair, or even 11;
- a design that samples `rdy` one cycle late shows one extra TW and captures stale read data.

Hold is raised both in IDLE and in the middle of a cycle. A design that grants hold before T4 cuts a cycle short and floats its strobes. Back-to-back requests and a misaligned word are also covered. The first catches a sequencer that forces an idle cycle. The second catches one that emits the reserved lane code or starts a cycle instead of flagging an error.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

   typedef enum logic [2:0] {
      TS_IDLE = 3'd0,
      TS_T1   = 3'd1,
      TS_T2   = 3'd2,
      TS_T3   = 3'd3,
      TS_TW   = 3'd4,
      TS_T4   = 3'd5,
      TS_HOLD = 3'd6
   } tstate_e;

   typedef struct packed {
      logic write;
      logic word;
      logic dma;
      logic bhe_n;
   } xfer_ctl_t;

endpackage

// File: rtl/mbs_lane_enc.sv
module mbs_lane_enc (
   input  logic addr0,
   input  logic word,
   output logic bhe_n,
   output logic misalign
);
   always_comb begin
      // word: both lanes; byte at odd address: upper lane; even: lower lane
      bhe_n    = !word && !addr0;
      misalign = word && addr0;
   end
endmodule

// File: rtl/mbs_tstate_fsm.sv
module mbs_tstate_fsm
   import mbs_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req_valid,
   input  logic    req_bad,
   input  logic    hold_req,
   input  logic    rdy,
   output tstate_e state,
   output logic    accept,
   output logic    reject
);
   tstate_e nxt;
   logic    issue_slot;

   always_comb begin
      issue_slot = (state == TS_IDLE) || (state == TS_T4);
      accept     = issue_slot && !hold_req && req_valid && !req_bad;
      reject     = issue_slot && !hold_req && req_valid && req_bad;
   end

   always_comb begin
      nxt = state;
      case (state)
         TS_IDLE: begin
            if (hold_req)    nxt = TS_HOLD;
            else if (accept) nxt = TS_T1;
         end
         TS_T1: nxt = TS_T2;
         TS_T2: nxt = TS_T3;
         TS_T3, TS_TW: nxt = rdy ? TS_T4 : TS_TW;
         TS_T4: begin
            if (hold_req)    nxt = TS_HOLD;
            else if (accept) nxt = TS_T1;
            else             nxt = TS_IDLE;
         end
         TS_HOLD: if (!hold_req) nxt = TS_IDLE;
         default: nxt = TS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= TS_IDLE;
      else        state <= nxt;
   end

   // R8: a low ready at the end of T3/TW yields another wait state
   a_r8_wait_on_low_ready: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == TS_T3 || state == TS_TW) && !rdy) |=> (state == TS_TW));
   // R8: a high ready at the end of T3/TW leads to T4
   a_r8_t4_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == TS_T3 || state == TS_TW) && rdy) |=> (state == TS_T4));
   // R9: hold entered only from a cycle boundary
   a_r9_hold_from_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TS_HOLD && $past(state) != TS_HOLD) |->
      ($past(state) == TS_IDLE || $past(state) == TS_T4));
endmodule

// File: rtl/mbs_pad_mux.sv
module mbs_pad_mux
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   localparam int STAT_W = ADDR_W - DATA_W
) (
   input  logic              rst_n,
   input  tstate_e           state,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  xfer_ctl_t         ctl,
   output logic              ale,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [STAT_W-1:0] ahi_out,
   output logic              bhe_n,
   output logic              wr_n,
   output logic              rd_n,
   output logic              ctl_oe
);
   logic in_bus;
   logic strobe_phase;
   logic data_phase;
   logic is_t1;

   always_comb begin
      is_t1        = (state == TS_T1);
      strobe_phase = (state == TS_T2) || (state == TS_T3) || (state == TS_TW);
      data_phase   = strobe_phase || (state == TS_T4);
      in_bus       = is_t1 || data_phase;
      ale          = is_t1;
      ad_out       = is_t1 ? addr[DATA_W-1:0] : wdata;
      ad_oe        = rst_n && (is_t1 || (ctl.write && data_phase));
      ctl_oe       = rst_n && (state != TS_HOLD);
      bhe_n        = in_bus ? ctl.bhe_n : 1'b1;
      wr_n         = !(strobe_phase && ctl.write);
      rd_n         = !(strobe_phase && !ctl.write);
   end

   // upper lines: address in T1; afterwards the top line reports origin, rest low
   for (genvar i = 0; i < STAT_W; i++) begin : g_stat
      if (i == STAT_W - 1) begin : g_origin
         assign ahi_out[i] = is_t1 ? addr[DATA_W+i] : ctl.dma;
      end else begin : g_zero
         assign ahi_out[i] = is_t1 ? addr[DATA_W+i] : 1'b0;
      end
   end

   // R1: nothing floatable is driven while reset is applied
   always_comb begin
      if (!rst_n) a_r1_float_in_reset: assert (!ad_oe && !ctl_oe);
   end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic                     req_write,
   input  logic                     req_word,
   input  logic                     req_dma,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     req_accept,
   output logic                     req_err,
   input  logic                     rdy,
   input  logic                     hold_req,
   output logic                     hold_ack,
   output logic                     ale,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     ad_oe,
   input  logic [DATA_W-1:0]        ad_in,
   output logic [ADDR_W-DATA_W-1:0] ahi_out,
   output logic                     bhe_n,
   output logic                     wr_n,
   output logic                     rd_n,
   output logic                     ctl_oe,
   output logic [DATA_W-1:0]        rdata,
   output logic                     rdata_valid
);
   localparam int STAT_W = ADDR_W - DATA_W;

   if (DATA_W != 16) begin : g_bad_data
      $error("mux_bus_seq: two byte lanes require DATA_W == 16");
   end
   if (STAT_W < 1) begin : g_bad_addr
      $error("mux_bus_seq: ADDR_W must exceed DATA_W");
   end

   tstate_e           state;
   logic              lane_bhe_n;
   logic              misalign;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   xfer_ctl_t         ctl_q;
   logic              capture;

   mbs_lane_enc u_lane (
      .addr0    (req_addr[0]),
      .word     (req_word),
      .bhe_n    (lane_bhe_n),
      .misalign (misalign)
   );

   mbs_tstate_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_bad   (misalign),
      .hold_req  (hold_req),
      .rdy       (rdy),
      .state     (state),
      .accept    (req_accept),
      .reject    (req_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         ctl_q   <= '{write: 1'b0, word: 1'b0, dma: 1'b0, bhe_n: 1'b1};
      end else if (req_accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         ctl_q   <= '{write: req_write, word: req_word, dma: req_dma, bhe_n: lane_bhe_n};
      end
   end

   always_comb capture = (state == TS_T3 || state == TS_TW) && rdy && !ctl_q.write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata       <= '0;
         rdata_valid <= 1'b0;
      end else begin
         rdata_valid <= capture;
         if (capture) rdata <= ad_in;
      end
   end

   always_comb hold_ack = (state == TS_HOLD);

   mbs_pad_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pads (
      .rst_n   (rst_n),
      .state   (state),
      .addr    (addr_q),
      .wdata   (wdata_q),
      .ctl     (ctl_q),
      .ale     (ale),
      .ad_out  (ad_out),
      .ad_oe   (ad_oe),
      .ahi_out (ahi_out),
      .bhe_n   (bhe_n),
      .wr_n    (wr_n),
      .rd_n    (rd_n),
      .ctl_oe  (ctl_oe)
   );

   // R2: the latch strobe lasts a single cycle
   a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);
   // R4: the reserved lane code is never presented
   a_r4_no_reserved_lane: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> !(bhe_n && ad_out[0]));
   // R5: byte-high status stays put while a strobe is active
   a_r5_bhe_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n || !rd_n) |-> $stable(bhe_n));
   // R6: the write strobe only starts right after the address phase
   a_r6_wr_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_n) |-> $past(ale));
   // R7: lines released while the read strobe is active
   a_r7_read_released: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);
   // R9: a held bus is fully floated
   a_r9_hold_floats: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> (!ctl_oe && !ad_oe && !req_accept));
   // R10: a rejected request starts no cycle
   a_r10_reject_no_ale: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |=> !ale);
endmodule

// File: tb/mux_bus_seq_tb_top.sv
module mux_bus_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write, req_word, req_dma;
   logic [19:0] req_addr;
   logic [15:0] req_wdata;
   logic        req_accept, req_err, rdy, hold_req, hold_ack, ale, ad_oe;
   logic [15:0] ad_out, ad_in, rdata;
   logic [3:0]  ahi_out;
   logic        bhe_n, wr_n, rd_n, ctl_oe, rdata_valid;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   mux_bus_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_word(req_word), .req_dma(req_dma),
      .req_wdata(req_wdata), .req_accept(req_accept), .req_err(req_err),
      .rdy(rdy), .hold_req(hold_req), .hold_ack(hold_ack), .ale(ale),
      .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ahi_out(ahi_out),
      .bhe_n(bhe_n), .wr_n(wr_n), .rd_n(rd_n), .ctl_oe(ctl_oe),
      .rdata(rdata), .rdata_valid(rdata_valid)
   );

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic drive_req(input logic [19:0] a, input bit w, input bit wd,
                            input bit dm, input logic [15:0] wdat);
      req_valid = 1'b1; req_addr = a; req_write = w; req_word = wd;
      req_dma = dm; req_wdata = wdat;
   endtask

   // one complete bus cycle, checked state by state
   task automatic xfer(input logic [19:0] a, input bit w, input bit wd, input bit dm,
                       input logic [15:0] wdat, input int waits, input logic [15:0] rv,
                       input bit predriven, input bit chain,
                       input logic [19:0] na, input bit hold_mid);
      logic exp_bhe;
      exp_bhe = !wd && !a[0];
      if (!predriven) begin
         @(negedge clk);
         drive_req(a, w, wd, dm, wdat);
         #1 chk("R2", "accept", req_accept, 1);
      end
      ad_in = rv; rdy = 1'b0;
      @(negedge clk);                 // T1
      req_valid = 1'b0;
      chk("R2", "ale in T1", ale, 1);
      chk("R2", "ad_oe in T1", ad_oe, 1);
      chk("R2", "addr low", ad_out, a[15:0]);
      chk("R2", "addr high", ahi_out, a[19:16]);
      chk("R4", "lane code", {bhe_n, ad_out[0]}, {exp_bhe, a[0]});
      chk("R6", "no strobe T1", {wr_n, rd_n}, 2'b11);
      @(negedge clk);                 // T2
      chk("R3", "status T2", ahi_out, {dm, 3'b000});
      chk("R5", "bhe T2", bhe_n, exp_bhe);
      chk("R2", "ale off T2", ale, 0);
      if (w) begin
         chk("R6", "wr_n T2", {wr_n, rd_n}, 2'b01);
         chk("R6", "wdata T2", {ad_oe, ad_out}, {1'b1, wdat});
      end else begin
         chk("R7", "rd_n T2", {wr_n, rd_n}, 2'b10);
         chk("R7", "released T2", ad_oe, 0);
      end
      if (hold_mid) hold_req = 1'b1;
      @(negedge clk);                 // T3
      chk("R9", "no early hold", {hold_ack, ctl_oe}, 2'b01);
      chk("R8", "strobe T3", wr_n & rd_n, 0);
      rdy = (waits == 0);
      for (int i = 1; i <= waits; i++) begin
         @(negedge clk);              // TW
         chk("R8", "strobe TW", wr_n & rd_n, 0);
         chk("R3", "status TW", ahi_out, {dm, 3'b000});
         rdy = (i == waits);
      end
      @(negedge clk);                 // T4
      rdy = 1'b0; ad_in = ~rv;
      chk("R8", "strobes off T4", {wr_n, rd_n}, 2'b11);
      chk("R5", "bhe T4", bhe_n, exp_bhe);
      chk("R3", "status T4", ahi_out, {dm, 3'b000});
      chk("R9", "no hold in T4", hold_ack, 0);
      if (w) begin
         chk("R6", "wdata T4", {ad_oe, ad_out}, {1'b1, wdat});
      end else begin
         chk("R7", "rdata T4", {rdata_valid, rdata}, {1'b1, rv});
         chk("R7", "released T4", ad_oe, 0);
      end
      if (chain) begin
         drive_req(na, 1'b0, 1'b1, 1'b0, 16'h0);
         #1 chk("R11", "accept in T4", req_accept, 1);
      end else begin
         @(negedge clk);
         if (hold_mid) begin
            chk("R9", "hold after T4", {hold_ack, ctl_oe, ad_oe}, 3'b100);
         end else begin
            chk("R11", "idle after T4", {ale, wr_n, rd_n}, 3'b011);
            if (!w) chk("R7", "rdata kept", {rdata_valid, rdata}, {1'b0, rv});
         end
      end
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
      req_word = 1'b0; req_dma = 1'b0; req_wdata = '0; rdy = 1'b0;
      hold_req = 1'b0; ad_in = '0;
      repeat (3) @(negedge clk);
      chk("R1", "oe in reset", {ad_oe, ctl_oe}, 2'b00);
      chk("R1", "ale/hold in reset", {ale, hold_ack}, 2'b00);
      rst_n = 1'b1;
      @(negedge clk);

      // sweep: direction x size x origin x parity x waits
      for (int w = 0; w < 2; w++)
         for (int wd = 0; wd < 2; wd++)
            for (int dm = 0; dm < 2; dm++)
               for (int a0 = 0; a0 < 2; a0++)
                  for (int ws = 0; ws < 3; ws++) begin
                     int idx;
                     logic [19:0] a;
                     idx = (((w * 2 + wd) * 2 + dm) * 2 + a0) * 3 + ws;
                     a = ((20'h5A3C0 + 20'(idx) * 20'h11111) & 20'hFFFFE) | 20'(a0);
                     if (wd == 1 && a0 == 1) begin
                        if (ws == 0) begin
                           @(negedge clk);
                           drive_req(a, w[0], 1'b1, dm[0], 16'h0);
                           #1 chk("R10", "misaligned err", {req_err, req_accept}, 2'b10);
                           @(negedge clk);
                           req_valid = 1'b0;
                           chk("R10", "no T1 after reject", ale, 0);
                        end
                     end else begin
                        xfer(a, w[0], wd[0], dm[0], 16'h1000 + 16'(idx) * 16'h00F1, ws,
                             16'hC000 ^ (16'(idx) * 16'h0123), 1'b0, 1'b0, 20'h0, 1'b0);
                     end
                  end

      // back-to-back: write, then a read accepted in T4
      xfer(20'hF0F02, 1'b1, 1'b1, 1'b1, 16'hBEEF, 1, 16'h0, 1'b0, 1'b1, 20'h13570, 1'b0);
      xfer(20'h13570, 1'b0, 1'b1, 1'b0, 16'h0, 0, 16'h5AA5, 1'b1, 1'b0, 20'h0, 1'b0);

      // hold from idle blocks requests
      @(negedge clk);
      hold_req = 1'b1;
      drive_req(20'h00200, 1'b0, 1'b1, 1'b0, 16'h0);
      #1 chk("R9", "no accept with hold", req_accept, 0);
      @(negedge clk);
      chk("R9", "hold granted", {hold_ack, ctl_oe, ad_oe, ale}, 4'b1000);
      chk("R9", "no accept in hold", req_accept, 0);
      hold_req = 1'b0; req_valid = 1'b0;
      @(negedge clk);
      chk("R9", "hold released", hold_ack, 0);

      // hold raised mid-cycle waits for T4
      xfer(20'h8ACE4, 1'b0, 1'b0, 1'b1, 16'h0, 2, 16'h7E81, 1'b0, 1'b0, 20'h0, 1'b1);
      hold_req = 1'b0;
      @(negedge clk);
      chk("R9", "hold dropped", {hold_ack, ctl_oe}, 2'b01);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule